// File: doc/BRIEF.md
# Descriptor Table Register Loader

This block runs the two privileged register loads of a segmented protection unit: loading the local descriptor table register and loading the task register, each from a 16-bit selector. A one-cycle `start` strobe, with `op_task` choosing the target, captures the selector, the current privilege level and the global table base and limit. The block first screens the selector without touching memory. It then reads the 8-byte descriptor as two 32-bit words through a request/acknowledge memory port and checks the descriptor's type and present bit. The load ends in one of two ways. Either a fault is reported, with a vector and an error code, or the selector and both descriptor words are latched into the target register and marked valid.

A task-register load that succeeds also writes the descriptor's high word back to memory with the busy bit set. Every operation ends with a one-cycle `done` pulse, and `fault` is qualified by that pulse.

The selector layout is as follows. Bits 15:3 are the table index, bit 2 is the table indicator and bits 1:0 are the requested privilege. In the descriptor high word, bits 11:8 hold the type, bit 12 is the code/data flag and bit 15 is the present bit.

Top module: `seg_table_loader`

## Requirements
- R1: When `cpl` is nonzero, the operation faults with vector 13 and error code 0. It makes no memory access and changes neither register. This check runs before every other check.
- R2: A local-table load with a null selector (bits 15:2 all zero) stores the selector into `ldt_sel`, clears `ldt_valid` and leaves `ldt_lo`/`ldt_hi` unchanged. It completes without a fault and without a memory access.
- R3: A task-register load with a null selector faults with vector 13 and error code 0, and makes no memory access.
- R4: A non-null selector with bit 2 set faults with vector 13. The error code is the selector with bits 1:0 cleared, and no memory access is made.
- R5: An entry whose last byte offset (index×8+7) exceeds `gdt_limit` faults with vector 13 and the masked-selector code, and no memory access is made.
- R6: The descriptor is read as a low word at `gdt_base`+index×8 and then a high word at +4. While `mem_req` is high and `mem_ack` is low, the request, address and write flag stay unchanged.
- R7: A local-table load accepts only a high word with bit 12 = 0 and type 2. A task-register load accepts only bit 12 = 0 with type 1 or type 9. Any other descriptor faults with vector 13 and the masked-selector code.
- R8: A descriptor that passes R7 but has bit 15 clear faults with vector 11 and the masked-selector code. A descriptor that fails both the type check and the present check reports the type fault.
- R9: A successful local-table load latches the selector and both descriptor words into `ldt_sel`/`ldt_lo`/`ldt_hi` and sets `ldt_valid`, without a fault.
- R10: A successful task-register load latches the selector and both words as read (before the busy bit is set) and sets `tr_valid`. Before `done`, it writes the high word with bit 9 set to the high-word address.
- R11: `done` is high for exactly one cycle per accepted operation. A `start` seen while `busy` is high is ignored.
- R12: After reset, `done`, `fault`, `busy`, `mem_req`, `ldt_valid` and `tr_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_task | input | 1 | 0: local-table load, 1: task-register load |
| sel_in | input | 16 | Selector to load |
| cpl | input | 2 | Current privilege level |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_limit | input | 16 | Global table limit in bytes |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| fault | output | 1 | The finishing operation faulted (with `done`) |
| fault_vec | output | 8 | Fault vector: 13 protection, 11 not present |
| fault_code | output | 16 | Fault error code |
| ldt_sel | output | 16 | Local-table register selector |
| ldt_lo | output | 32 | Local-table descriptor low word |
| ldt_hi | output | 32 | Local-table descriptor high word |
| ldt_valid | output | 1 | Local-table register holds a valid descriptor |
| tr_sel | output | 16 | Task register selector |
| tr_lo | output | 32 | Task descriptor low word |
| tr_hi | output | 32 | Task descriptor high word (as read) |
| tr_valid | output | 1 | Task register holds a valid descriptor |

## Verification
Both operations are swept over every combination of table index, table-indicator bit and requested privilege at privilege 0, against a 16-entry table with a limit that covers only 12 entries. The table mixes the accepted types, a wrong type, a set code/data flag and a cleared present bit, so each outcome separates the selector screening, the type rule, the type-before-present order and the success path. A second pass at nonzero privilege, including the null selector, shows that the privilege check takes precedence over the null-selector handling. The memory answers after a varying number of wait cycles, so the request hold and the busy write-back are checked against different acknowledge timings. A start pulse given while an operation is running shows that the second request is dropped.

// File: rtl/stl_pkg.sv
package stl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ_LO,
    ST_READ_HI,
    ST_VALIDATE,
    ST_WRITE_BUSY,
    ST_DONE
  } stl_state_e;

  localparam logic [7:0] VEC_PROT   = 8'd13;
  localparam logic [7:0] VEC_ABSENT = 8'd11;

  localparam int SEL_TI_BIT  = 2;
  localparam int DSC_TYPE_LO = 8;
  localparam int DSC_BUSY    = 9;
  localparam int DSC_S_BIT   = 12;
  localparam int DSC_P_BIT   = 15;

  localparam logic [3:0] TYPE_LOCAL_TABLE = 4'h2;
  localparam logic [3:0] TYPE_TASK16_FREE = 4'h1;
  localparam logic [3:0] TYPE_TASK32_FREE = 4'h9;

  localparam int NUM_TARGETS = 2;
  localparam int TGT_LOCAL   = 0;
  localparam int TGT_TASK    = 1;

  typedef struct packed {
    logic [15:0] sel;
    logic [31:0] lo;
    logic [31:0] hi;
    logic        valid;
  } stl_treg_t;

endpackage

// File: rtl/stl_sel_check.sv
module stl_sel_check
  import stl_pkg::*;
(
  input  logic        op_task,
  input  logic [15:0] sel,
  input  logic [1:0]  cpl,
  input  logic [15:0] limit,
  output logic        chk_fault,
  output logic [15:0] chk_code,
  output logic        null_local
);

  logic        is_null;
  logic [15:0] entry_end;
  logic [15:0] masked_sel;

  assign is_null    = (sel[15:2] == 14'd0);
  assign entry_end  = {sel[15:3], 3'b111};
  assign masked_sel = {sel[15:2], 2'b00};

  always_comb begin
    chk_fault  = 1'b0;
    chk_code   = 16'd0;
    null_local = 1'b0;
    if (cpl != 2'd0) begin
      chk_fault = 1'b1;
    end else if (is_null) begin
      if (op_task) chk_fault  = 1'b1;
      else         null_local = 1'b1;
    end else if (sel[SEL_TI_BIT]) begin
      chk_fault = 1'b1;
      chk_code  = masked_sel;
    end else if (entry_end > limit) begin
      chk_fault = 1'b1;
      chk_code  = masked_sel;
    end
  end

endmodule

// File: rtl/stl_desc_check.sv
module stl_desc_check
  import stl_pkg::*;
(
  input  logic        op_task,
  input  logic [31:0] hi_word,
  output logic        type_ok,
  output logic        present
);

  logic [3:0] dtype;
  logic       is_system;

  assign dtype     = hi_word[DSC_TYPE_LO +: 4];
  assign is_system = ~hi_word[DSC_S_BIT];
  assign present   = hi_word[DSC_P_BIT];

  always_comb begin
    if (!is_system)   type_ok = 1'b0;
    else if (op_task) type_ok = (dtype == TYPE_TASK16_FREE) || (dtype == TYPE_TASK32_FREE);
    else              type_ok = (dtype == TYPE_LOCAL_TABLE);
  end

endmodule

// File: rtl/stl_treg.sv
module stl_treg
  import stl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        inval,
  input  logic [15:0] sel,
  input  logic [31:0] lo,
  input  logic [31:0] hi,
  output stl_treg_t   q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q.sel   <= sel;
      q.lo    <= lo;
      q.hi    <= hi;
      q.valid <= 1'b1;
    end else if (inval) begin
      q.sel   <= sel;
      q.valid <= 1'b0;
    end
  end

  assert_load_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q.valid && q.sel == $past(sel) && q.hi == $past(hi)));

  assert_null_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inval && !load) |=> (!q.valid && $stable(q.lo) && $stable(q.hi)));

endmodule

// File: rtl/seg_table_loader.sv
module seg_table_loader
  import stl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_task,
  input  logic [15:0]       sel_in,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [15:0]       gdt_limit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [7:0]        fault_vec,
  output logic [15:0]       fault_code,
  output logic [15:0]       ldt_sel,
  output logic [31:0]       ldt_lo,
  output logic [31:0]       ldt_hi,
  output logic              ldt_valid,
  output logic [15:0]       tr_sel,
  output logic [31:0]       tr_lo,
  output logic [31:0]       tr_hi,
  output logic              tr_valid
);

  localparam logic [ADDR_W-1:0] HI_OFFSET = ADDR_W'(4);
  localparam logic [31:0]       BUSY_MASK = 32'h1 << DSC_BUSY;

  stl_state_e        state_q, state_d;
  logic              op_q;
  logic [15:0]       sel_q;
  logic [1:0]        cpl_q;
  logic [ADDR_W-1:0] base_q;
  logic [15:0]       limit_q;
  logic [31:0]       lo_q, hi_q;
  logic              fault_q;
  logic [7:0]        vec_q;
  logic [15:0]       code_q;

  logic              accept;
  logic              chk_fault, null_local;
  logic [15:0]       chk_code;
  logic              type_ok, present;
  logic [ADDR_W-1:0] entry_addr;
  logic [15:0]       masked_sel;

  logic              set_fault;
  logic [7:0]        set_vec;
  logic [15:0]       set_code;
  logic              lo_en, hi_en;
  logic              commit_ok;
  logic [NUM_TARGETS-1:0] tgt_load, tgt_inval;
  stl_treg_t         tgt_q [NUM_TARGETS];

  assign accept     = (state_q == ST_IDLE) && start;
  assign entry_addr = base_q + ADDR_W'({sel_q[15:3], 3'b000});
  assign masked_sel = {sel_q[15:2], 2'b00};

  stl_sel_check u_sel_check (
    .op_task    (op_q),
    .sel        (sel_q),
    .cpl        (cpl_q),
    .limit      (limit_q),
    .chk_fault  (chk_fault),
    .chk_code   (chk_code),
    .null_local (null_local)
  );

  stl_desc_check u_desc_check (
    .op_task (op_q),
    .hi_word (hi_q),
    .type_ok (type_ok),
    .present (present)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:       if (start) state_d = ST_CHECK;
      ST_CHECK:      state_d = (chk_fault || null_local) ? ST_DONE : ST_READ_LO;
      ST_READ_LO:    if (mem_ack) state_d = ST_READ_HI;
      ST_READ_HI:    if (mem_ack) state_d = ST_VALIDATE;
      ST_VALIDATE: begin
        if (!type_ok || !present) state_d = ST_DONE;
        else if (op_q)            state_d = ST_WRITE_BUSY;
        else                      state_d = ST_DONE;
      end
      ST_WRITE_BUSY: if (mem_ack) state_d = ST_DONE;
      ST_DONE:       state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  // Fault selection: type check ranks above the present check
  always_comb begin
    set_fault = 1'b0;
    set_vec   = VEC_PROT;
    set_code  = 16'd0;
    if (state_q == ST_CHECK && chk_fault) begin
      set_fault = 1'b1;
      set_code  = chk_code;
    end else if (state_q == ST_VALIDATE && !type_ok) begin
      set_fault = 1'b1;
      set_code  = masked_sel;
    end else if (state_q == ST_VALIDATE && !present) begin
      set_fault = 1'b1;
      set_vec   = VEC_ABSENT;
      set_code  = masked_sel;
    end
  end

  assign lo_en     = (state_q == ST_READ_LO) && mem_ack;
  assign hi_en     = (state_q == ST_READ_HI) && mem_ack;
  assign commit_ok = (state_q == ST_VALIDATE) && type_ok && present;

  assign tgt_load[TGT_LOCAL]  = commit_ok && !op_q;
  assign tgt_load[TGT_TASK]   = commit_ok && op_q;
  assign tgt_inval[TGT_LOCAL] = (state_q == ST_CHECK) && null_local;
  assign tgt_inval[TGT_TASK]  = 1'b0;

  // State and datapath registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= 1'b0;
      sel_q   <= 16'd0;
      cpl_q   <= 2'd0;
      base_q  <= '0;
      limit_q <= 16'd0;
      lo_q    <= 32'd0;
      hi_q    <= 32'd0;
      fault_q <= 1'b0;
      vec_q   <= 8'd0;
      code_q  <= 16'd0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q    <= op_task;
        sel_q   <= sel_in;
        cpl_q   <= cpl;
        base_q  <= gdt_base;
        limit_q <= gdt_limit;
        fault_q <= 1'b0;
      end
      if (lo_en) lo_q <= mem_rdata;
      if (hi_en) hi_q <= mem_rdata;
      if (set_fault) begin
        fault_q <= 1'b1;
        vec_q   <= set_vec;
        code_q  <= set_code;
      end
    end
  end

  for (genvar g = 0; g < NUM_TARGETS; g++) begin : g_tgt
    stl_treg u_treg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tgt_load[g]),
      .inval (tgt_inval[g]),
      .sel   (sel_q),
      .lo    (lo_q),
      .hi    (hi_q),
      .q     (tgt_q[g])
    );
  end

  assign mem_req   = (state_q == ST_READ_LO) || (state_q == ST_READ_HI) ||
                     (state_q == ST_WRITE_BUSY);
  assign mem_we    = (state_q == ST_WRITE_BUSY);
  assign mem_addr  = (state_q == ST_READ_LO) ? entry_addr : entry_addr + HI_OFFSET;
  assign mem_wdata = hi_q | BUSY_MASK;

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign fault      = done && fault_q;
  assign fault_vec  = vec_q;
  assign fault_code = code_q;

  assign ldt_sel   = tgt_q[TGT_LOCAL].sel;
  assign ldt_lo    = tgt_q[TGT_LOCAL].lo;
  assign ldt_hi    = tgt_q[TGT_LOCAL].hi;
  assign ldt_valid = tgt_q[TGT_LOCAL].valid;
  assign tr_sel    = tgt_q[TGT_TASK].sel;
  assign tr_lo     = tgt_q[TGT_TASK].lo;
  assign tr_hi     = tgt_q[TGT_TASK].hi;
  assign tr_valid  = tgt_q[TGT_TASK].valid;

  assert_cpl_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && cpl_q != 2'd0) |=>
      (done && fault && fault_vec == VEC_PROT && fault_code == 16'd0));

  assert_screen_no_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && chk_fault) |=> (!mem_req && $stable(ldt_valid) && $stable(tr_valid)));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_absent_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_vec == VEC_ABSENT) |-> (fault_code[1:0] == 2'b00 && fault_code != 16'd0));

  assert_busy_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (op_q && tr_valid && mem_wdata[DSC_BUSY] &&
                             mem_addr == entry_addr + HI_OFFSET));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/tb_seg_table_loader.sv
module tb_seg_table_loader;

  localparam logic [31:0] BASE  = 32'h0000_2000;
  localparam logic [15:0] LIMIT = 16'd95;   // entries 0..11 inside

  logic        clk, rst_n;
  logic        start, op_task;
  logic [15:0] sel_in;
  logic [1:0]  cpl;
  logic [31:0] gdt_base;
  logic [15:0] gdt_limit;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, done, fault;
  logic [7:0]  fault_vec;
  logic [15:0] fault_code;
  logic [15:0] ldt_sel, tr_sel;
  logic [31:0] ldt_lo, ldt_hi, tr_lo, tr_hi;
  logic        ldt_valid, tr_valid;

  seg_table_loader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_task(op_task), .sel_in(sel_in),
    .cpl(cpl), .gdt_base(gdt_base), .gdt_limit(gdt_limit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fault(fault), .fault_vec(fault_vec), .fault_code(fault_code),
    .ldt_sel(ldt_sel), .ldt_lo(ldt_lo), .ldt_hi(ldt_hi), .ldt_valid(ldt_valid),
    .tr_sel(tr_sel), .tr_lo(tr_lo), .tr_hi(tr_hi), .tr_valid(tr_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] mem [32];
  int          ack_delay = 0;
  int          wait_cnt = 0;
  int          acc_cnt = 0;
  int          wr_cnt = 0;
  logic [31:0] last_waddr, last_wdata;

  function automatic logic [31:0] lo_init(int i);
    return 32'hA500_0000 | (32'(i) * 32'h111);
  endfunction

  function automatic logic [31:0] hi_init(int i);
    logic [31:0] r;
    logic [3:0]  t;
    case (i % 4)
      0: t = 4'h5;
      1: t = 4'h1;
      2: t = 4'h2;
      default: t = 4'h9;
    endcase
    r        = 32'd0;
    r[31:24] = 8'(i);
    r[15]    = ((i / 4) != 1);
    r[12]    = ((i / 4) == 2);
    r[11:8]  = t;
    r[7:0]   = 8'h40 + 8'(i);
    return r;
  endfunction

  // Memory responder: waits ack_delay cycles, then acknowledges for one cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack   = 1'b0;
      mem_rdata = 32'd0;
      wait_cnt  = 0;
    end else if (mem_req) begin
      if (mem_ack) begin
        mem_ack  = 1'b0;
        wait_cnt = 0;
      end else if (wait_cnt >= ack_delay) begin
        int w;
        w = int'((mem_addr - BASE) >> 2);
        mem_ack  = 1'b1;
        wait_cnt = 0;
        acc_cnt++;
        if (w >= 0 && w < 32) begin
          if (mem_we) begin
            mem[w]     = mem_wdata;
            wr_cnt++;
            last_waddr = mem_addr;
            last_wdata = mem_wdata;
          end else begin
            mem_rdata = mem[w];
          end
        end else begin
          mem_rdata = 32'hDEAD_BEEF;
        end
      end else begin
        wait_cnt++;
      end
    end else begin
      mem_ack  = 1'b0;
      wait_cnt = 0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected state of the two target registers
  logic [15:0] e_ldt_sel = 16'd0, e_tr_sel = 16'd0;
  logic [31:0] e_ldt_lo = 32'd0, e_ldt_hi = 32'd0, e_tr_lo = 32'd0, e_tr_hi = 32'd0;
  logic        e_ldt_v = 1'b0, e_tr_v = 1'b0;

  int    e_kind;     // 0 fault, 1 local null, 2 success
  logic  [7:0]  e_vec;
  logic  [15:0] e_code;
  int    e_acc;
  string e_req;

  task automatic model(input logic op, input logic [15:0] s, input logic [1:0] c);
    int idx;
    logic [31:0] h;
    logic ok;
    idx    = int'(s[15:3]);
    e_kind = 0; e_vec = 8'd13; e_code = {s[15:2], 2'b00}; e_acc = 0;
    if (c != 2'd0) begin
      e_code = 16'd0; e_req = "R1";
    end else if (s[15:2] == 14'd0) begin
      if (op) begin e_code = 16'd0; e_req = "R3"; end
      else    begin e_kind = 1; e_req = "R2"; end
    end else if (s[2]) begin
      e_req = "R4";
    end else if (idx * 8 + 7 > int'(LIMIT)) begin
      e_req = "R5";
    end else begin
      e_acc = 2;
      h  = mem[2*idx+1];
      ok = !h[12] && (op ? (h[11:8] == 4'h1 || h[11:8] == 4'h9) : (h[11:8] == 4'h2));
      if (!ok)        e_req = "R7";
      else if (!h[15]) begin e_vec = 8'd11; e_req = "R8"; end
      else begin
        e_kind = 2; e_acc = op ? 3 : 2; e_req = op ? "R10" : "R9";
      end
    end
  endtask

  task automatic run_op(input logic op, input logic [15:0] s, input logic [1:0] c);
    int idx;
    int t;
    logic [31:0] hi_orig;
    idx     = int'(s[15:3]);
    hi_orig = mem[2*idx+1];
    model(op, s, c);
    acc_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    op_task = op; sel_in = s; cpl = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 100) begin @(negedge clk); t++; end
    chk("R11", "done seen", 32'(done), 32'd1);
    chk(e_req, "fault", 32'(fault), 32'(e_kind == 0));
    if (e_kind == 0) begin
      chk(e_req, "vector", 32'(fault_vec), 32'(e_vec));
      chk(e_req, "code", 32'(fault_code), 32'(e_code));
    end
    chk(e_req, "accesses", 32'(acc_cnt), 32'(e_acc));
    if (e_kind == 1) begin
      e_ldt_sel = s; e_ldt_v = 1'b0;
    end else if (e_kind == 2 && !op) begin
      e_ldt_sel = s; e_ldt_lo = mem[2*idx]; e_ldt_hi = hi_orig; e_ldt_v = 1'b1;
    end else if (e_kind == 2 && op) begin
      e_tr_sel = s; e_tr_lo = mem[2*idx]; e_tr_hi = hi_orig; e_tr_v = 1'b1;
      chk("R10", "write count", 32'(wr_cnt), 32'd1);
      chk("R10", "write addr", last_waddr, BASE + 32'(idx) * 8 + 4);
      chk("R10", "write data", last_wdata, hi_orig | 32'h200);
    end
    chk(e_req, "ldt_sel", 32'(ldt_sel), 32'(e_ldt_sel));
    chk(e_req, "ldt_lo", ldt_lo, e_ldt_lo);
    chk(e_req, "ldt_hi", ldt_hi, e_ldt_hi);
    chk(e_req, "ldt_valid", 32'(ldt_valid), 32'(e_ldt_v));
    chk(e_req, "tr_sel", 32'(tr_sel), 32'(e_tr_sel));
    chk(e_req, "tr_lo", tr_lo, e_tr_lo);
    chk(e_req, "tr_hi", tr_hi, e_tr_hi);
    chk(e_req, "tr_valid", 32'(tr_valid), 32'(e_tr_v));
    @(negedge clk);
    chk("R11", "done low after pulse", 32'(done), 32'd0);
    mem[2*idx+1] = hi_orig;
    ack_delay = (ack_delay + 1) % 3;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[2*i]   = lo_init(i);
      mem[2*i+1] = hi_init(i);
    end
    rst_n = 1'b0; start = 1'b0; op_task = 1'b0; sel_in = 16'd0; cpl = 2'd0;
    gdt_base = BASE; gdt_limit = LIMIT;
    repeat (3) @(negedge clk);
    chk("R12", "done", 32'(done), 32'd0);
    chk("R12", "fault", 32'(fault), 32'd0);
    chk("R12", "busy", 32'(busy), 32'd0);
    chk("R12", "mem_req", 32'(mem_req), 32'd0);
    chk("R12", "ldt_valid", 32'(ldt_valid), 32'd0);
    chk("R12", "tr_valid", 32'(tr_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Full sweep at privilege 0
    for (int op = 0; op < 2; op++)
      for (int idx = 0; idx < 16; idx++)
        for (int ti = 0; ti < 2; ti++)
          for (int rpl = 0; rpl < 4; rpl++)
            run_op(op[0], {idx[12:0], ti[0], rpl[1:0]}, 2'd0);

    // Nonzero privilege, including null selectors (R1 before R2/R3)
    for (int c = 1; c < 4; c++)
      for (int op = 0; op < 2; op++) begin
        run_op(op[0], 16'h0000, c[1:0]);
        run_op(op[0], 16'h0011, c[1:0]);
        run_op(op[0], 16'h004B, c[1:0]);
      end

    // Start while busy is ignored (R11)
    begin
      int t;
      logic [31:0] h2;
      h2 = mem[5];
      acc_cnt = 0;
      @(negedge clk);
      op_task = 1'b0; sel_in = 16'h0010; cpl = 2'd0; start = 1'b1;
      @(negedge clk);
      op_task = 1'b1; sel_in = 16'h0008;   // second request while busy
      @(negedge clk);
      start = 1'b0;
      t = 0;
      while (!done && t < 100) begin @(negedge clk); t++; end
      chk("R11", "first op fault", 32'(fault), 32'd0);
      chk("R11", "ldt_sel from first", 32'(ldt_sel), 32'h0010);
      chk("R11", "ldt_hi from first", ldt_hi, h2);
      chk("R11", "tr unchanged", 32'(tr_sel), 32'(e_tr_sel));
      t = 0;
      repeat (12) begin @(negedge clk); if (done) t++; end
      chk("R11", "no second done", 32'(t), 32'd0);
      chk("R11", "accesses", 32'(acc_cnt), 32'd2);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule